// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This unit converts a "store bytes" request into exactly one aligned memory write with per-byte enables. A request carries a byte address, a register value, a fill mode and a unit size. In begin mode the store covers the addressed byte through the last byte of the aligned unit. In end mode it covers the first byte of the unit up to, but not including, the addressed byte. The unit is 4 bytes in word mode and 8 bytes in doubleword mode.

The output beat carries the address rounded down to an 8-byte boundary, an 8-bit byte-enable vector and 64 bits of data on big-endian byte lanes. A store of 3, 5, 6 or 7 bytes is therefore one indivisible masked write and never a sequence of smaller writes. An end-mode store at offset zero writes no byte. In that case the write strobe stays low and a probe flag asks the memory side to run the store-permission check and mark the line modified. One register stage with a valid/ready handshake sits between request and beat.

Top module: `pwst_store_lanes`

## Requirements
- R1: After reset `out_valid`, `out_write` and `out_probe` are 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A request accepted on a clock edge is presented on the output after that edge. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R3: `out_addr` equals `in_addr` with its three low bits cleared.
- R4: Lane mapping is big-endian. `out_be[k]` qualifies `out_data[8k+7:8k]`, and that lane holds the byte at offset 7-k of the 8-byte unit.
- R5: A doubleword begin store at offset o = `in_addr[2:0]` gives `out_be = 8'hFF >> o`. Offset 0 writes all 8 lanes and offset 7 writes only lane 0. Each enabled lane carries the same lane of `in_value`, so the least significant bytes of the value are stored.
- R6: A doubleword end store at offset o gives `out_be = ~(8'hFF >> o)`. Offsets 7, 6 and 5 give 7, 6 and 5 bytes. Each enabled lane carries the same lane of `in_value`, so the most significant bytes of the value are stored.
- R7: In word mode, `in_addr[2]` selects the half. Half 0 uses lanes 7..4 and half 1 uses lanes 3..0. Within the half, o = `in_addr[1:0]`. Begin mode enables the 4-bit mask `4'hF >> o` and end mode enables its complement. The word `in_value[31:0]` is placed on the selected half in the same byte order. A begin store at offset 1 of half 0 gives `8'h70`, and an end store at offset 3 gives `8'hE0`.
- R8: Every lane whose enable is 0 carries zero data. In word mode this includes the whole unselected half.
- R9: An end store at offset 0 (word or doubleword) gives `out_be = 0`, `out_probe = 1` and `out_write = 0`. Every other request gives `out_probe = 0`, `out_write = 1` and a nonzero `out_be`.
- R10: Each accepted request produces exactly one output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when high together with in_valid |
| in_addr | input | ADDR_W | Byte address of the store |
| in_value | input | DATA_W | Register value to store from |
| in_end_mode | input | 1 | 0 = begin mode, 1 = end mode |
| in_dword | input | 1 | 0 = 4-byte unit, 1 = 8-byte unit |
| out_valid | output | 1 | Write beat present |
| out_ready | input | 1 | Memory side takes the beat |
| out_addr | output | ADDR_W | Address aligned to 8 bytes |
| out_be | output | DATA_W/8 | Byte enables, bit k for data lane k |
| out_data | output | DATA_W | Data on big-endian byte lanes |
| out_write | output | 1 | Write strobe, low for a probe-only beat |
| out_probe | output | 1 | Permission check requested, no byte written |

## Verification
The bench targets the first and last offsets of both unit sizes. A design with an off-by-one mask would write 8 bytes where 7 were meant, or write nothing at begin offset 7. It also targets end mode at offset 0 in both sizes. A design that got this wrong would raise the write strobe, enable lanes, or fail to ask for the probe. Word stores are sent to both halves, because a swapped half select would put the data at the wrong four addresses. It also checks that idle lanes read zero, which a design that leaks value bytes would break. Stalls from the memory side check that a held beat does not change or get duplicated, and random traffic covers the remaining offset, mode and size combinations.

// File: rtl/pwst_pkg.sv
package pwst_pkg;

    // Lane selection rule shared by both unit sizes.
    // pos  : byte position inside the unit (0 = lowest address)
    // ofs  : addressed offset inside the unit
    // head : 1 = end mode (fill head up to ofs), 0 = begin mode (fill from ofs)
    function automatic logic lane_on(int unsigned pos, int unsigned ofs, logic head);
        return head ? (pos < ofs) : (pos >= ofs);
    endfunction

endpackage

// File: rtl/pwst_lane_mask.sv
module pwst_lane_mask #(
    parameter int NB = 8
) (
    input  logic [$clog2(NB)-1:0] ofs,
    input  logic                  head,
    input  logic                  dword,
    output logic [NB-1:0]         be
);
    import pwst_pkg::*;

    localparam int OFS_W  = $clog2(NB);
    localparam int WB     = NB / 2;
    localparam int WOFS_W = $clog2(WB);

    logic [WOFS_W-1:0] wofs;
    assign wofs = ofs[WOFS_W-1:0];

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // lane k holds the byte at unit position NB-1-k (big-endian)
        localparam int unsigned POS  = NB - 1 - k;
        localparam int unsigned HALF = POS / WB;
        localparam int unsigned WPOS = POS % WB;

        always_comb begin
            if (dword) begin
                be[k] = lane_on(POS, int'(ofs), head);
            end else begin
                be[k] = (ofs[OFS_W-1] == 1'(HALF)) && lane_on(WPOS, int'(wofs), head);
            end
        end
    end

endmodule

// File: rtl/pwst_lane_steer.sv
module pwst_lane_steer #(
    parameter int NB = 8
) (
    input  logic [8*NB-1:0] value,
    input  logic [NB-1:0]   be,
    input  logic            dword,
    output logic [8*NB-1:0] data
);
    localparam int WB = NB / 2;

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // in word mode both halves map onto the low word of the value
        localparam int unsigned SRC = k % WB;
        logic [7:0] src;

        always_comb begin
            src = dword ? value[8*k +: 8] : value[8*SRC +: 8];
            data[8*k +: 8] = be[k] ? src : 8'h00;
        end
    end

endmodule

// File: rtl/pwst_out_stage.sv
module pwst_out_stage #(
    parameter int ADDR_W = 32,
    parameter int NB     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [NB-1:0]     nxt_be,
    input  logic [8*NB-1:0]   nxt_data,
    input  logic              nxt_probe,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [NB-1:0]     out_be,
    output logic [8*NB-1:0]   out_data,
    output logic              out_write,
    output logic              out_probe
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [NB-1:0]     be;
        logic [8*NB-1:0]   data;
        logic              probe;
    } beat_t;

    beat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = nxt_addr;
            st_d.be    = nxt_be;
            st_d.data  = nxt_data;
            st_d.probe = nxt_probe;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = !st_q.valid || out_ready;
    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;
    assign out_be    = st_q.be;
    assign out_data  = st_q.data;
    assign out_write = st_q.valid && !st_q.probe;
    assign out_probe = st_q.valid && st_q.probe;

endmodule

// File: rtl/pwst_store_lanes.sv
module pwst_store_lanes #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [DATA_W-1:0]   in_value,
    input  logic                in_end_mode,
    input  logic                in_dword,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [DATA_W/8-1:0] out_be,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_write,
    output logic                out_probe
);
    localparam int NB     = DATA_W / 8;
    localparam int OFS_W  = $clog2(NB);
    localparam int WOFS_W = OFS_W - 1;

    logic [OFS_W-1:0]  ofs;
    logic [OFS_W-1:0]  ofs_eff;
    logic [ADDR_W-1:0] base_addr;
    logic [NB-1:0]     be_c;
    logic [DATA_W-1:0] data_c;
    logic              probe_c;
    logic              load;

    always_comb begin
        ofs       = in_addr[OFS_W-1:0];
        ofs_eff   = in_dword ? ofs : {1'b0, ofs[WOFS_W-1:0]};
        base_addr = {in_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        probe_c   = in_end_mode && (ofs_eff == '0);
    end

    pwst_lane_mask #(.NB(NB)) u_mask (
        .ofs   (ofs),
        .head  (in_end_mode),
        .dword (in_dword),
        .be    (be_c)
    );

    pwst_lane_steer #(.NB(NB)) u_steer (
        .value (in_value),
        .be    (be_c),
        .dword (in_dword),
        .data  (data_c)
    );

    assign load = in_valid && in_ready;

    pwst_out_stage #(.ADDR_W(ADDR_W), .NB(NB)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .nxt_addr  (base_addr),
        .nxt_be    (be_c),
        .nxt_data  (data_c),
        .nxt_probe (probe_c),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_be    (out_be),
        .out_data  (out_data),
        .out_write (out_write),
        .out_probe (out_probe)
    );

endmodule

// File: rtl/pwst_store_lanes_chk.sv
module pwst_store_lanes_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [ADDR_W-1:0]   out_addr,
    input logic [DATA_W/8-1:0] out_be,
    input logic [DATA_W-1:0]   out_data,
    input logic                out_write,
    input logic                out_probe
);
    localparam int NB    = DATA_W / 8;
    localparam int OFS_W = $clog2(NB);

    logic [DATA_W-1:0] lane_bits;
    for (genvar k = 0; k < NB; k++) begin : g_bits
        assign lane_bits[8*k +: 8] = {8{out_be[k]}};
    end

    // R9
    probe_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_probe |-> (out_be == '0) && !out_write);

    // R9
    write_has_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_probe |-> out_write && (out_be != '0));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_be) && $stable(out_data)
                                    && $stable(out_addr) && $stable(out_probe));

    // R2
    accept_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R2
    ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R3
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[OFS_W-1:0] == '0));

    // R8
    idle_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~lane_bits) == '0));

endmodule

bind pwst_store_lanes pwst_store_lanes_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_be    (out_be),
    .out_data  (out_data),
    .out_write (out_write),
    .out_probe (out_probe)
);

// File: tb/tb_pwst_store_lanes.sv
`timescale 1ns/1ps
module tb_pwst_store_lanes;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_value = '0;
    logic          in_end_mode = 1'b0;
    logic          in_dword = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic [7:0]    out_be;
    logic [DW-1:0] out_data;
    logic          out_write;
    logic          out_probe;

    int n_checks = 0;
    int n_fail   = 0;
    int n_sent   = 0;
    int n_beats  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pwst_store_lanes #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_value(in_value), .in_end_mode(in_end_mode), .in_dword(in_dword),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_be(out_be), .out_data(out_data), .out_write(out_write),
        .out_probe(out_probe)
    );

    always @(posedge clk) if (rst_n && out_valid && out_ready) n_beats++;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected model written from unit positions (0 = lowest address).
    function automatic logic [7:0] exp_be(input logic [AW-1:0] a, input bit e, input bit d);
        logic [7:0] m = '0;
        for (int i = 0; i < 8; i++) begin
            bit on;
            if (d) begin
                on = e ? (i < int'(a[2:0])) : (i >= int'(a[2:0]));
            end else begin
                on = ((i / 4) == int'(a[2])) &&
                     (e ? ((i % 4) < int'(a[1:0])) : ((i % 4) >= int'(a[1:0])));
            end
            m[7-i] = on;
        end
        return m;
    endfunction

    function automatic logic [63:0] exp_data(input logic [63:0] v, input logic [AW-1:0] a,
                                             input bit e, input bit d);
        logic [63:0] r = '0;
        logic [7:0]  m = exp_be(a, e, d);
        for (int i = 0; i < 8; i++) begin
            if (m[7-i]) begin
                if (d) r[8*(7-i) +: 8] = v[8*(7-i) +: 8];
                else   r[8*(7-i) +: 8] = v[8*(3-(i%4)) +: 8];
            end
        end
        return r;
    endfunction

    task automatic send(input logic [AW-1:0] a, input logic [63:0] v, input bit e,
                        input bit d, input int hold, input string tag);
        logic [7:0]  xbe = exp_be(a, e, d);
        logic [63:0] xd  = exp_data(v, a, e, d);
        bit          xp  = e && (d ? (a[2:0] == 3'd0) : (a[1:0] == 2'd0));
        @(negedge clk);
        in_addr = a; in_value = v; in_end_mode = e; in_dword = d;
        in_valid = 1'b1; out_ready = 1'b1;
        check(in_ready == 1'b1, "R2 ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        n_sent++;
        if (hold > 0) out_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid", 64'(out_valid), 64'd1);
        check(out_addr == {a[AW-1:3], 3'b000}, "R3 addr", 64'(out_addr), 64'({a[AW-1:3], 3'b000}));
        check(out_be == xbe, {tag, " be"}, 64'(out_be), 64'(xbe));
        check(out_data == xd, {tag, " data R8"}, out_data, xd);
        check(out_probe == xp && out_write == !xp, "R9 probe/write",
              64'({out_probe, out_write}), 64'({xp, !xp}));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(out_valid && out_be == xbe && out_data == xd && !in_ready,
                  "R2 hold", 64'({out_valid, in_ready, out_be}), 64'({1'b1, 1'b0, xbe}));
        end
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!out_valid && !out_write && !out_probe && in_ready, "R1 during reset",
              64'({out_valid, out_write, out_probe, in_ready}), 64'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_write && !out_probe && in_ready, "R1 after reset",
              64'({out_valid, out_write, out_probe, in_ready}), 64'b0001);

        // directed corners: R5 doubleword begin
        send(32'h1000, 64'h0102030405060708, 1'b0, 1'b1, 0, "R5 dw begin o0");
        check(out_be == 8'hFF, "R5 full", 64'(out_be), 64'hFF);
        send(32'h1007, 64'h0102030405060708, 1'b0, 1'b1, 0, "R5 dw begin o7");
        check(out_be == 8'h01 && out_data == 64'h08, "R4 R5 one byte lane0",
              out_data, 64'h08);
        send(32'h1001, 64'hA1A2A3A4A5A6A7A8, 1'b0, 1'b1, 0, "R5 dw begin o1");
        check(out_be == 8'h7F, "R5 7 bytes", 64'(out_be), 64'h7F);
        // R6 doubleword end
        send(32'h2007, 64'hB1B2B3B4B5B6B7B8, 1'b1, 1'b1, 0, "R6 dw end o7");
        check(out_be == 8'hFE, "R6 7 bytes", 64'(out_be), 64'hFE);
        send(32'h2005, 64'hB1B2B3B4B5B6B7B8, 1'b1, 1'b1, 0, "R6 dw end o5");
        check(out_data == 64'hB1B2B3B4B5000000, "R6 msbytes", out_data, 64'hB1B2B3B4B5000000);
        send(32'h2000, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b1, 0, "R9 dw end o0");
        check(out_probe && !out_write && out_be == 8'h00, "R9 dw probe",
              64'({out_probe, out_write, out_be}), 64'h200);
        // R7 word mode, both halves
        send(32'h3001, 64'hDEADBEEF11223344, 1'b0, 1'b0, 0, "R7 w begin o1 h0");
        check(out_be == 8'h70 && out_data == 64'h0022334400000000, "R7 begin half0",
              out_data, 64'h0022334400000000);
        send(32'h3003, 64'hDEADBEEF11223344, 1'b1, 1'b0, 0, "R7 w end o3 h0");
        check(out_be == 8'hE0, "R7 end mask", 64'(out_be), 64'hE0);
        send(32'h3005, 64'hDEADBEEF11223344, 1'b0, 1'b0, 0, "R7 w begin o1 h1");
        check(out_be == 8'h07 && out_data == 64'h0000000000223344, "R7 begin half1 R8",
              out_data, 64'h0000000000223344);
        send(32'h3004, 64'h5555555555555555, 1'b1, 1'b0, 0, "R9 w end o0 h1");
        check(out_probe && !out_write, "R9 word probe", 64'({out_probe, out_write}), 64'b10);
        // R2 backpressure
        send(32'h4002, 64'h0011223344556677, 1'b0, 1'b1, 3, "R2 stall");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a = $urandom();
            logic [63:0]   v = {$urandom(), $urandom()};
            bit            e = 1'($urandom_range(0, 1));
            bit            d = 1'($urandom_range(0, 1));
            int            h = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
            send(a, v, e, d, h, "R5 R6 R7 random");
        end

        @(negedge clk);
        @(negedge clk);
        // R10 one beat per request
        check(n_beats == n_sent && !out_valid, "R10 beat count", 64'(n_beats), 64'(n_sent));
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule